// File: doc/BRIEF.md
# Reloading Interval Down-Counter

This block is a 16-bit periodic interval timer. Software sets a reload value and picks a count rate from a small prescaler. Setting a start bit makes the counter count down once per count-source tick. When it passes zero it loads the reload value again and raises a request flag. The flag stays set until software clears it. The interval is therefore (reload + 1) count-source ticks. With a 32 MHz clock, the divide-by-8 source and a reload of 39999, this gives a 10 ms tick.

The start bit is a command. A separate count-status output reports whether counting is actually in progress. That status follows the start bit only when a count-source tick occurs, so both starting and stopping are acknowledged up to one source period late. The source select uses a non-monotonic code map, and some codes are reserved. A reserved code produces no ticks at all.

Top module: `rld_timer`

## Requirements
- R1: After reset the count reads FFFFh, the count status is 0 and the request flag is 0.
- R2: Source code 000 gives a tick every clock, code 011 every 2nd clock and code 001 every 8th clock. The prescaler phase starts from zero when the start bit is written to 1 from the idle state.
- R3: While counting, each tick decrements the count. With divisor D, the first request flag appears (reload + 2)·D clocks after the start write, because the status needs one tick before counting begins.
- R4: When a tick arrives at count 0, the count reloads from the reload register and the flag is set, losing no tick. Later flags follow every (reload + 1)·D clocks.
- R5: The count status rises on the first tick after the start bit is set and falls on the first tick after it is cleared. It never changes between ticks.
- R6: While the count status is 0, the count holds its value except on a reload write.
- R7: Source codes 010 and 111 (and every other code outside 000, 001, 011) produce no ticks. The status then stays 0 and the count stays frozen even with the start bit set.
- R8: The request flag is sticky until a clear pulse. If a clear arrives on the same cycle as a new underflow, the flag stays set.
- R9: A reload write while idle (start bit 0 and status 0) also loads the count. While counting, it only changes the value used at the next underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reload_wr | input | 1 | Write strobe for the reload register |
| reload_din | input | 16 | Reload value (valid range 0001h to FFFFh) |
| mode_wr | input | 1 | Write strobe for the source select |
| mode_src | input | 3 | Count-source code |
| start_wr | input | 1 | Write strobe for the start bit |
| start_din | input | 1 | Start bit value to write |
| flag_clr | input | 1 | Clears the request flag |
| cnt_val | output | 16 | Current count |
| run_stat | output | 1 | Count-in-progress status |
| req_flag | output | 1 | Sticky interval request flag |

## Verification
The hardest case to reach from the ports is a flag clear landing on exactly the clock edge where an underflow sets the flag again. The bench uses the divide-by-2 source with reload 1, which gives a 4-clock interval. It clears the flag once, then times a second clear pulse to the computed underflow edge. Stopping in the middle of a divide-by-8 prescale is also hard to observe. The bench writes the stop at a known phase and checks two things: the status stays high until the next eighth clock, and the count takes one last decrement on that tick.

// File: rtl/rld_pkg.sv
package rld_pkg;
  localparam int SRC_W = 3;
  localparam logic [SRC_W-1:0] SRC_CLK  = 3'b000;
  localparam logic [SRC_W-1:0] SRC_DIV8 = 3'b001;
  localparam logic [SRC_W-1:0] SRC_DIV2 = 3'b011;

  function automatic logic src_valid(input logic [SRC_W-1:0] s);
    return (s == SRC_CLK) || (s == SRC_DIV8) || (s == SRC_DIV2);
  endfunction
endpackage

// File: rtl/rld_prescale.sv
module rld_prescale
  import rld_pkg::*;
#(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [SRC_W-1:0] src,
  output logic             tick
);
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst || !en) pre <= '0;
    else            pre <= pre + 1'b1;
  end

  always_comb begin
    case (src)
      SRC_CLK:  tick = en;
      SRC_DIV2: tick = en & pre[0];
      SRC_DIV8: tick = en & (&pre[2:0]);
      default:  tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/rld_runsync.sv
module rld_runsync (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic running
);
  always_ff @(posedge clk) begin
    if (rst)       running <= 1'b0;
    else if (tick) running <= start;
  end
endmodule

// File: rtl/rld_core.sv
module rld_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             running,
  input  logic             idle,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_din,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] reload_q,
  output logic             flag
);
  localparam logic [CNT_W-1:0] RST_VAL = '1;
  logic step, wrap;

  assign step = tick & running;
  assign wrap = step & (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= RST_VAL;
      reload_q <= RST_VAL;
      flag     <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= reload_din;
      if (step) begin
        if (wrap) cnt <= reload_q;
        else      cnt <= cnt - 1'b1;
      end else if (reload_wr && idle) begin
        cnt <= reload_din;
      end
      if (wrap)          flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end
endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import rld_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_din,
  input  logic             mode_wr,
  input  logic [SRC_W-1:0] mode_src,
  input  logic             start_wr,
  input  logic             start_din,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cnt_val,
  output logic             run_stat,
  output logic             req_flag
);
  logic             start_q;
  logic [SRC_W-1:0] src_q;
  logic             src_tick;
  logic [CNT_W-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= 1'b0;
      src_q   <= SRC_CLK;
    end else begin
      if (start_wr) start_q <= start_din;
      if (mode_wr)  src_q   <= mode_src;
    end
  end

  rld_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .en(start_q | run_stat), .src(src_q), .tick(src_tick)
  );

  rld_runsync u_run (
    .clk(clk), .rst(rst), .tick(src_tick), .start(start_q), .running(run_stat)
  );

  rld_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .tick(src_tick), .running(run_stat),
    .idle(!start_q && !run_stat), .reload_wr(reload_wr), .reload_din(reload_din),
    .flag_clr(flag_clr), .cnt(cnt_val), .reload_q(reload_q), .flag(req_flag)
  );
endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk
  import rld_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tick,
  input logic             run,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] rld,
  input logic             flag,
  input logic             clr,
  input logic             rwr,
  input logic [SRC_W-1:0] src
);
  AST_STATUS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(run)); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr) |=> flag); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!run && !rwr) |=> $stable(cnt)); // R6
  AST_RELOAD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (tick && run && cnt == '0) |=> (cnt == $past(rld) && flag)); // R4
  AST_DECREMENT: assert property (@(posedge clk) disable iff (rst)
    (tick && run && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R3
  AST_RESERVED_SILENT: assert property (@(posedge clk) disable iff (rst)
    !src_valid(src) |-> !tick); // R7
endmodule

bind rld_timer rld_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .tick(src_tick), .run(run_stat), .cnt(cnt_val),
  .rld(reload_q), .flag(req_flag), .clr(flag_clr), .rwr(reload_wr), .src(src_q)
);

// File: tb/sim_rld_timer.sv
module sim_rld_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reload_wr = 1'b0;
  logic [15:0] reload_din = '0;
  logic        mode_wr = 1'b0;
  logic [2:0]  mode_src = '0;
  logic        start_wr = 1'b0;
  logic        start_din = 1'b0;
  logic        flag_clr = 1'b0;
  logic [15:0] cnt_val;
  logic        run_stat;
  logic        req_flag;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rld_timer u0 (
    .clk(clk), .rst(rst), .reload_wr(reload_wr), .reload_din(reload_din),
    .mode_wr(mode_wr), .mode_src(mode_src), .start_wr(start_wr), .start_din(start_din),
    .flag_clr(flag_clr), .cnt_val(cnt_val), .run_stat(run_stat), .req_flag(req_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reload(input int v);
    reload_din = 16'(v); reload_wr = 1'b1; @(negedge clk); reload_wr = 1'b0;
  endtask

  task automatic wr_mode(input int v);
    mode_src = 3'(v); mode_wr = 1'b1; @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic wr_start(input bit v);
    start_din = v; start_wr = 1'b1; @(negedge clk); start_wr = 1'b0;
  endtask

  task automatic clr_pulse();
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 count", int'(cnt_val), 16'hFFFF);
    chk("R1 status", int'(run_stat), 0);
    chk("R1 flag", int'(req_flag), 0);
  endtask

  task automatic t_div1();
    wr_mode(0); clr_pulse(); wr_reload(3);
    chk("R9 idle load", int'(cnt_val), 3);
    wr_start(1'b1);
    chk("R5 status lag", int'(run_stat), 0);
    step(1); chk("R5 status rise", int'(run_stat), 1);
    step(3); chk("R3 flag early", int'(req_flag), 0);
    step(1); chk("R3 flag on time", int'(req_flag), 1);
    chk("R4 reload", int'(cnt_val), 3);
    clr_pulse(); chk("R8 clear", int'(req_flag), 0);
    step(2); chk("R4 not yet", int'(req_flag), 0);
    step(1); chk("R4 period", int'(req_flag), 1);
    wr_start(1'b0); chk("R5 stop lag", int'(run_stat), 1);
    step(1); chk("R5 status fall", int'(run_stat), 0);
    chk("R6 last count", int'(cnt_val), 1);
    step(4); chk("R6 hold", int'(cnt_val), 1);
    clr_pulse();
  endtask

  task automatic t_div8();
    wr_mode(1); wr_reload(2);
    chk("R9 idle load div8", int'(cnt_val), 2);
    wr_start(1'b1);
    step(7); chk("R2 div8 status lag", int'(run_stat), 0);
    step(1); chk("R2 div8 status rise", int'(run_stat), 1);
    step(7); chk("R2 div8 hold", int'(cnt_val), 2);
    step(1); chk("R2 div8 decrement", int'(cnt_val), 1);
    step(15); chk("R3 div8 early", int'(req_flag), 0);
    step(1); chk("R3 div8 flag", int'(req_flag), 1);
    wr_reload(5); chk("R9 running write", int'(cnt_val), 2);
    step(22); chk("R4 zero", int'(cnt_val), 0);
    step(1); chk("R9 new reload used", int'(cnt_val), 5);
    wr_start(1'b0); chk("R5 div8 stop lag", int'(run_stat), 1);
    step(6); chk("R5 div8 still on", int'(run_stat), 1);
    step(1); chk("R5 div8 fall", int'(run_stat), 0);
    step(6); chk("R6 div8 frozen", int'(cnt_val), 4);
    clr_pulse();
  endtask

  task automatic t_div2();
    wr_mode(3); wr_reload(1);
    chk("R9 idle load div2", int'(cnt_val), 1);
    wr_start(1'b1);
    step(1); chk("R2 div2 status lag", int'(run_stat), 0);
    step(1); chk("R2 div2 status rise", int'(run_stat), 1);
    step(3); chk("R3 div2 early", int'(req_flag), 0);
    step(1); chk("R3 div2 flag", int'(req_flag), 1);
    step(1); clr_pulse(); chk("R8 cleared", int'(req_flag), 0);
    step(1); clr_pulse(); chk("R8 set wins", int'(req_flag), 1);
    wr_start(1'b0); step(4);
    chk("R5 div2 stopped", int'(run_stat), 0);
    clr_pulse();
  endtask

  task automatic t_reserved();
    for (int i = 0; i < 2; i++) begin
      wr_mode(i == 0 ? 2 : 7); wr_reload(4); wr_start(1'b1);
      step(40);
      chk("R7 no status", int'(run_stat), 0);
      chk("R7 count frozen", int'(cnt_val), 4);
      chk("R7 no flag", int'(req_flag), 0);
      wr_start(1'b0); step(2);
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_div1();
    t_div8();
    t_div2();
    t_reserved();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule